// File: doc/BRIEF.md
# Load/Store Size and Sign Unit

This unit sits between a 32-bit core and byte-addressed memory. It takes one memory operation at a time: a four-bit control field (store or load, signed extension, access size), a destination register index, a base value and a 16-bit offset, plus the data to store. The effective byte address is the base plus the sign-extended offset. From that address and the size, the unit derives the byte-lane enables. For stores it also moves the store data onto the lanes being written.

The memory side uses a single-beat valid/ready handshake. For a load, the memory returns read data in the same cycle that it raises ready. The unit then picks the addressed byte or halfword out of the 32-bit word and extends it with zeros or with its sign bit. The result appears on the load-result port for exactly one cycle, tagged with the destination index.

An access of the reserved size, or one that is not aligned to its own size, never reaches memory. It raises a one-cycle fault pulse instead.

The controller has four states:
- IDLE: accepts an operation.
- MEM: a request is outstanding.
- RESP: the one-cycle load-result pulse.
- FAULT: the one-cycle fault pulse.

The transitions are:
- IDLE→MEM: a legal operation is accepted.
- IDLE→FAULT: an illegal operation is accepted.
- MEM→IDLE: a store is acknowledged.
- MEM→RESP: a load is acknowledged.
- RESP→IDLE and FAULT→IDLE: unconditional.

Top module: `mem_size_unit`

## Requirements
- R1: `in_ctrl[3]` = 1 is a store and 0 is a load; `in_ctrl[2]` selects sign extension; `in_ctrl[1:0]` is the size (00 byte, 01 halfword, 10 word, 11 reserved). `mem_we` equals the store bit of the accepted operation.
- R2: `mem_addr` equals `in_base` plus `in_imm` sign-extended to 32 bits, modulo 2^32.
- R3: `mem_be` is 0001 shifted left by `addr[1:0]` for a byte, 0011 shifted left by 2·`addr[1]` for a halfword, and 1111 for a word.
- R4: For a store, `mem_wdata` carries store byte 0 (byte), bytes 1:0 (halfword) or all four bytes (word) on the enabled lanes, and zero on every other lane.
- R5: A load returns the addressed byte or halfword of `mem_rdata`, zero-extended when `in_ctrl[2]` = 0 and sign-extended when it is 1; a word load returns the whole word.
- R6: For a store, the sign bit has no effect on `mem_be` or `mem_wdata`.
- R7: Size 11, a halfword at an odd address, or a word whose address is not a multiple of 4, gives `fault` = 1 for one cycle, in the cycle after acceptance, and no memory request is made.
- R8: While `mem_valid` = 1 and `mem_ready` = 0, the request stays up and `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold their values.
- R9: A load gives `ld_valid` = 1 for exactly one cycle, in the cycle after the handshake, with `ld_dest` equal to the accepted destination index. A store gives no `ld_valid`.
- R10: `in_ready` = 1 only in IDLE. After reset, `in_ready` = 1 and `mem_valid`, `ld_valid` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_ctrl | input | 4 | {store, signed, size[1:0]} |
| in_dest | input | 4 | Destination register index |
| in_base | input | 32 | Base register value |
| in_imm | input | 16 | Signed address offset |
| in_store_data | input | 32 | Store data, right-aligned |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts or answers this cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word, valid with mem_ready |
| ld_valid | output | 1 | Load result pulse |
| ld_dest | output | 4 | Destination index of the result |
| ld_data | output | 32 | Extended load result |
| fault | output | 1 | Misaligned or reserved-size pulse |

## Verification
The assertions assume that memory raises ready only while a request is up, and that read data is meaningful in the cycle ready is high. They also assume that `in_valid` may be asserted at any time, so an offer outside IDLE has to be ignored. The stimulus respects these assumptions because the memory model in the bench answers only open requests, with random wait states, and serves data from its own array. Random base values and offsets mix all four sizes and both directions. Roughly half the bases are aligned, so that both legal and faulting accesses occur often. Directed cases cover offset wrap-around, the sign bit at its limits, and the reserved size.

// File: rtl/mem_size_pkg.sv
package mem_size_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_RESP,
        ST_FAULT
    } unit_state_e;
endpackage

// File: rtl/msu_addr_gen.sv
module msu_addr_gen
    import mem_size_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int LANES  = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] addr,
    output logic              bad
);
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W-1:0] off;
    logic             misalign;

    // offset is sign-extended before the add
    assign addr = base + {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign off  = addr[OFF_W-1:0];

    always_comb begin
        misalign = 1'b0;
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = off[0];
            SZ_WORD: misalign = (off != '0);
            default: misalign = 1'b1;
        endcase
    end

    assign bad = misalign;
endmodule

// File: rtl/msu_store_align.sv
module msu_store_align
    import mem_size_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e                    size,
    input  logic [$clog2(DATA_W/8)-1:0]  off,
    input  logic [DATA_W-1:0]            data,
    output logic [DATA_W/8-1:0]          be,
    output logic [DATA_W-1:0]            wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic       sel;
        logic [7:0] src_byte;

        always_comb begin
            sel      = 1'b0;
            src_byte = data[7:0];
            unique case (size)
                SZ_BYTE: begin
                    sel      = (off == OFF_W'(l));
                    src_byte = data[7:0];
                end
                SZ_HALF: begin
                    sel      = (off[OFF_W-1:1] == (OFF_W-1)'(l / 2));
                    src_byte = data[8*(l%2) +: 8];
                end
                SZ_WORD: begin
                    sel      = 1'b1;
                    src_byte = data[8*l +: 8];
                end
                default: begin
                    sel      = 1'b0;
                    src_byte = data[7:0];
                end
            endcase
        end

        assign be[l]             = sel;
        assign wdata[8*l +: 8]   = sel ? src_byte : 8'h00;
    end
endmodule

// File: rtl/msu_load_extract.sv
module msu_load_extract
    import mem_size_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e                    size,
    input  logic                         sgn,
    input  logic [$clog2(DATA_W/8)-1:0]  off,
    input  logic [DATA_W-1:0]            rdata,
    output logic [DATA_W-1:0]            data
);
    localparam int OFF_W = $clog2(DATA_W/8);

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    assign sel_b = rdata[{off, 3'b000} +: 8];
    assign sel_h = rdata[{off[OFF_W-1:1], 4'b0000} +: 16];

    always_comb begin
        unique case (size)
            SZ_BYTE: data = sgn ? {{(DATA_W-8){sel_b[7]}}, sel_b}
                                : {{(DATA_W-8){1'b0}}, sel_b};
            SZ_HALF: data = sgn ? {{(DATA_W-16){sel_h[15]}}, sel_h}
                                : {{(DATA_W-16){1'b0}}, sel_h};
            default: data = rdata;
        endcase
    end
endmodule

// File: rtl/mem_size_unit.sv
module mem_size_unit
    import mem_size_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int RIDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [3:0]           in_ctrl,
    input  logic [RIDX_W-1:0]    in_dest,
    input  logic [ADDR_W-1:0]    in_base,
    input  logic [IMM_W-1:0]     in_imm,
    input  logic [DATA_W-1:0]    in_store_data,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W/8-1:0]  mem_be,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 ld_valid,
    output logic [RIDX_W-1:0]    ld_dest,
    output logic [DATA_W-1:0]    ld_data,
    output logic                 fault
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    unit_state_e state_q, state_d;

    // decode of the compact control field
    logic      op_store, op_sgn;
    acc_size_e op_size;
    assign op_store = in_ctrl[3];
    assign op_sgn   = in_ctrl[2];
    assign op_size  = acc_size_e'(in_ctrl[1:0]);

    logic [ADDR_W-1:0] ea;
    logic              op_bad;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wdata_c;
    logic [DATA_W-1:0] ext_c;

    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q, sgn_q;
    acc_size_e         size_q;
    logic [RIDX_W-1:0] dest_q;
    logic [DATA_W-1:0] ld_q;
    logic              accept;

    msu_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .LANES(LANES)) u_addr (
        .base (in_base),
        .imm  (in_imm),
        .size (op_size),
        .addr (ea),
        .bad  (op_bad)
    );

    msu_store_align #(.DATA_W(DATA_W)) u_align (
        .size  (op_size),
        .off   (ea[OFF_W-1:0]),
        .data  (in_store_data),
        .be    (be_c),
        .wdata (wdata_c)
    );

    msu_load_extract #(.DATA_W(DATA_W)) u_extract (
        .size  (size_q),
        .sgn   (sgn_q),
        .off   (addr_q[OFF_W-1:0]),
        .rdata (mem_rdata),
        .data  (ext_c)
    );

    assign accept = in_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = op_bad ? ST_FAULT : ST_MEM;
            ST_MEM:   if (mem_ready) state_d = we_q ? ST_IDLE : ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            sgn_q   <= 1'b0;
            size_q  <= SZ_BYTE;
            dest_q  <= '0;
            ld_q    <= '0;
        end else begin
            if (accept) begin
                addr_q  <= ea;
                be_q    <= be_c;
                wdata_q <= op_store ? wdata_c : '0;
                we_q    <= op_store;
                sgn_q   <= op_sgn;
                size_q  <= op_size;
                dest_q  <= in_dest;
            end
            if (state_q == ST_MEM && mem_ready && !we_q) ld_q <= ext_c;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        mem_valid = (state_q == ST_MEM);
        ld_valid  = (state_q == ST_RESP);
        fault     = (state_q == ST_FAULT);
        mem_we    = we_q;
        mem_addr  = addr_q;
        mem_be    = be_q;
        mem_wdata = wdata_q;
        ld_dest   = dest_q;
        ld_data   = ld_q;
    end

    logic [DATA_W-1:0] lane_mask;
    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign lane_mask[8*l +: 8] = {8{mem_be[l]}};
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_we) && $stable(mem_wdata)); // R8
    AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_valid && !ld_valid); // R7
    AST_FAULT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault && in_ready); // R7
    AST_LD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid); // R9
    AST_LD_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_valid && mem_ready && !mem_we)); // R9
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && (mem_be == '1) |-> mem_addr[OFF_W-1:0] == '0); // R3
    AST_BE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_be != '0); // R3
    AST_STORE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> (mem_wdata & ~lane_mask) == '0); // R4
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_valid && !ld_valid && !fault); // R10
endmodule

// File: tb/test_mem_size_unit.sv
module test_mem_size_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [3:0]  in_ctrl;
    logic [3:0]  in_dest;
    logic [31:0] in_base;
    logic [15:0] in_imm;
    logic [31:0] in_store_data;
    logic        mem_valid;
    logic        mem_ready;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        ld_valid;
    logic [3:0]  ld_dest;
    logic [31:0] ld_data;
    logic        fault;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    logic [31:0] bmem [16];

    always #5 clk = ~clk;

    assign mem_rdata = bmem[mem_addr[5:2]];

    mem_size_unit i_mem_size_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctrl(in_ctrl), .in_dest(in_dest), .in_base(in_base), .in_imm(in_imm),
        .in_store_data(in_store_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_dest(ld_dest), .ld_data(ld_data),
        .fault(fault)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] f_addr(logic [31:0] b, logic [15:0] i);
        return b + {{16{i[15]}}, i};
    endfunction

    function automatic bit f_bad(logic [1:0] sz, logic [31:0] a);
        return (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    endfunction

    function automatic logic [3:0] f_be(logic [1:0] sz, logic [31:0] a);
        case (sz)
            2'b00:   return 4'b0001 << a[1:0];
            2'b01:   return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] f_wdata(logic [1:0] sz, logic [31:0] a, logic [31:0] v);
        int sh;
        case (sz)
            2'b00: begin sh = 8 * int'(a[1:0]); return {24'b0, v[7:0]} << sh; end
            2'b01: begin sh = 16 * int'(a[1]);  return {16'b0, v[15:0]} << sh; end
            default: return v;
        endcase
    endfunction

    function automatic logic [31:0] f_load(logic [31:0] w, logic [1:0] sz, logic [31:0] a, bit s);
        logic [31:0] t;
        int sh;
        case (sz)
            2'b00: begin
                sh = 8 * int'(a[1:0]); t = w >> sh;
                return s ? {{24{t[7]}}, t[7:0]} : {24'b0, t[7:0]};
            end
            2'b01: begin
                sh = 16 * int'(a[1]); t = w >> sh;
                return s ? {{16{t[15]}}, t[15:0]} : {16'b0, t[15:0]};
            end
            default: return w;
        endcase
    endfunction

    task automatic run_op(bit st, bit sg, logic [1:0] sz, logic [3:0] rd,
                          logic [31:0] base, logic [15:0] imm, logic [31:0] sv);
        logic [31:0] a, exp_ld, w, m;
        logic [3:0]  be;
        bit bad;
        a   = f_addr(base, imm);
        bad = f_bad(sz, a);
        be  = f_be(sz, a);
        @(negedge clk);
        in_ctrl = {st, sg, sz}; in_dest = rd; in_base = base; in_imm = imm;
        in_store_data = sv; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_ctrl = 4'($urandom); in_base = $urandom; in_imm = 16'($urandom);
        in_store_data = $urandom; in_dest = 4'($urandom);
        #1;
        if (bad) begin
            chk("R7", "fault pulse", 32'(fault), 32'd1);
            chk("R7", "no request", 32'(mem_valid), 32'd0);
            @(negedge clk); #1;
            chk("R7", "fault ends", 32'(fault), 32'd0);
            chk("R10", "ready after fault", 32'(in_ready), 32'd1);
            return;
        end
        chk("R10", "busy while requesting", 32'(in_ready), 32'd0);
        for (int k = 0; k < 64; k++) begin
            mem_ready = (k >= 8) ? 1'b1 : 1'($urandom_range(0, 1));
            #1;
            if (mem_valid && mem_ready) begin
                chk("R2", "address", mem_addr, a);
                chk("R1", "write flag", 32'(mem_we), 32'(st));
                chk("R3", "byte enables", 32'(mem_be), 32'(be));
                if (st) begin
                    chk(sg ? "R6" : "R4", "write data", mem_wdata, f_wdata(sz, a, sv));
                    w = bmem[a[5:2]];
                    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
                    bmem[a[5:2]] = (w & ~m) | (f_wdata(sz, a, sv) & m);
                end else begin
                    exp_ld = f_load(bmem[a[5:2]], sz, a, sg);
                end
                @(negedge clk);
                mem_ready = 1'b0;
                #1;
                if (st) begin
                    chk("R9", "no result for store", 32'(ld_valid), 32'd0);
                    chk("R10", "idle after store", 32'(in_ready), 32'd1);
                end else begin
                    chk("R9", "result pulse", 32'(ld_valid), 32'd1);
                    chk("R9", "result dest", 32'(ld_dest), 32'(rd));
                    chk("R5", "load data", ld_data, exp_ld);
                    @(negedge clk); #1;
                    chk("R9", "pulse ends", 32'(ld_valid), 32'd0);
                    chk("R10", "idle after load", 32'(in_ready), 32'd1);
                end
                return;
            end
            chk("R8", "request held", 32'(mem_valid), 32'd1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) bmem[i] = $urandom;
        rst_n = 1'b0; in_valid = 1'b0; in_ctrl = '0; in_dest = '0; in_base = '0;
        in_imm = '0; in_store_data = '0; mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "reset ready", 32'(in_ready), 32'd1);
        chk("R10", "reset mem_valid", 32'(mem_valid), 32'd0);
        chk("R10", "reset ld_valid", 32'(ld_valid), 32'd0);
        chk("R10", "reset fault", 32'(fault), 32'd0);
        rst_n = 1'b1;

        // directed corner cases
        run_op(1, 0, 2'b10, 4'd1, 32'h0000_0100, 16'h0000, 32'hDEAD_BEEF); // word store
        run_op(0, 0, 2'b10, 4'd2, 32'h0000_0100, 16'h0000, 32'h0);         // word load back
        run_op(1, 0, 2'b00, 4'd3, 32'h0000_0010, 16'hFFF3, 32'h0000_0080); // negative offset, lane 3
        run_op(0, 1, 2'b00, 4'd4, 32'h0000_0010, 16'hFFF3, 32'h0);         // R5 signed byte 0x80
        run_op(0, 0, 2'b00, 4'd5, 32'h0000_0010, 16'hFFF3, 32'h0);         // R5 unsigned byte
        run_op(1, 1, 2'b01, 4'd6, 32'h0000_0020, 16'h0002, 32'h1234_8001); // R6 signed bit on store
        run_op(0, 1, 2'b01, 4'd7, 32'h0000_0020, 16'h0002, 32'h0);         // signed half 0x8001
        run_op(0, 0, 2'b01, 4'd8, 32'h0000_0021, 16'h0000, 32'h0);         // R7 odd half
        run_op(1, 0, 2'b10, 4'd9, 32'h0000_0002, 16'h0000, 32'h0);         // R7 word at 2
        run_op(0, 0, 2'b11, 4'd10, 32'h0000_0000, 16'h0000, 32'h0);        // R7 reserved size
        run_op(0, 1, 2'b10, 4'd11, 32'hFFFF_FFFC, 16'h0008, 32'h0);        // R2 wrap-around

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [31:0] b;
            b = $urandom;
            if ($urandom_range(0, 1) == 1) b[1:0] = 2'b00;
            run_op(1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom), b,
                   16'($urandom_range(0, 1) ? $urandom_range(0, 64) : $urandom), $urandom);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule